// File: doc/BRIEF.md
# Interleaved multiphase PWM generator

This block drives the gate-control bits of a multiphase converter. One free-running main counter sweeps through `RES` states per switching period. Each of the `N_PHASE` phase slices adds its own fixed offset to that count and folds the sum back into the counter range. It then compares the folded count against one shared duty word. The result is `N_PHASE` copies of the same PWM waveform, spread evenly over the switching period.

The duty word comes from an outside regulator. It is sampled in two places: in the one start-up cycle after reset, and at every counter wrap. All phases therefore switch to a new duty at the same period boundary, and no phase sees a partial period. A small sequencer has two states. `SEQ_PRIME` is the single cycle after reset: the counter is held at 0, the first duty is loaded and the outputs are forced low. `SEQ_RUN` is normal counting. The only transitions are reset (any state to `SEQ_PRIME`) and prime-done (`SEQ_PRIME` to `SEQ_RUN`, unconditional). `SEQ_RUN` then stays in `SEQ_RUN` until the next reset.

Top module: `interleaved_pwm`

## Requirements
- R1: The main counter steps by one each cycle in `SEQ_RUN` through 0..RES-1 and wraps to 0. Every phase output therefore repeats with a period of exactly RES cycles (RES = 420 by default).
- R2: Phase k uses the offset floor(k*RES/N_PHASE). Its rising edge comes (RES - offset) mod RES cycles after the rising edge of phase 0.
- R3: Phase k's folded count is (count + offset) mod RES. Its output bit k of `pwm_o` is 1 exactly when that folded count is strictly less than the latched duty.
- R4: A latched duty of 0 holds every output at 0.
- R5: A latched duty of RES or more (up to 511) holds every output at 1 in `SEQ_RUN`.
- R6: `duty_i` is latched only in the cycle where the counter wraps from RES-1 to 0. A change in the middle of a period has no effect before that wrap. All phases then switch to the new duty on the same cycle.
- R7: While `rst` is high, the counter and the latched duty are cleared and all outputs are 0 at the next edge.
- R8: In `SEQ_PRIME`, the cycle right after reset, `duty_i` is latched. The first period after reset uses that value, and its outputs appear two cycles after reset is released.
- R9: Over any RES consecutive cycles with one latched duty D, each phase is high for min(D, RES) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | 9 | Duty word (clog2(RES+1) bits), sampled at wrap |
| pwm_o | output | 16 | One drive bit per phase (N_PHASE bits), registered |

## Verification
The duty word is tried at several kinds of value:
- **Interior values** (100, 105, 300) show that the offsets and the fold place each phase's edges correctly.
- **Values of 1 and RES-1** expose off-by-one errors in the strict less-than compare and in the fold boundary.
- **A duty of 0, exactly RES, and the largest code** separate the forced-low case from the forced-high case, and show that values above RES saturate.
- **A duty change in mid-period**, and a reset in mid-run followed by a new start-up duty, show whether the word is taken only at the wrap and in the prime cycle, rather than at once.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;
    typedef enum logic [0:0] {
        SEQ_PRIME = 1'b0,
        SEQ_RUN   = 1'b1
    } seq_state_e;
endpackage

// File: rtl/ipwm_sequencer.sv
module ipwm_sequencer
    import ipwm_pkg::*;
#(
    parameter int RES = 420,
    parameter int CW  = 9,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] duty_i,
    output logic [CW-1:0] cnt_o,
    output logic [DW-1:0] duty_o,
    output logic          run_o
);
    localparam logic [CW-1:0] LAST = CW'(RES - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] duty_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_PRIME: state_d = SEQ_RUN;
            SEQ_RUN:   state_d = SEQ_RUN;
            default:   state_d = SEQ_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_PRIME;
        else     state_q <= state_d;
    end

    // counter and duty latch, driven by the state
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_PRIME: begin
                    cnt_q  <= '0;
                    duty_q <= duty_i;
                end
                SEQ_RUN: begin
                    if (at_last) begin
                        cnt_q  <= '0;
                        duty_q <= duty_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q  <= '0;
                    duty_q <= '0;
                end
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign duty_o = duty_q;
    assign run_o  = (state_q == SEQ_RUN);
endmodule

// File: rtl/ipwm_phase.sv
module ipwm_phase #(
    parameter int RES = 420,
    parameter int CW  = 9,
    parameter int DW  = 9,
    parameter int OFF = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [DW-1:0] duty_i,
    output logic          pwm_o
);
    localparam int SW = (CW + 1 > DW) ? CW + 1 : DW;
    localparam logic [CW:0] OFF_V = (CW + 1)'(OFF);
    localparam logic [CW:0] RES_V = (CW + 1)'(RES);

    logic [CW:0] sum_w;
    logic [CW:0] fold_w;
    logic        hit_w;
    logic        pwm_q;

    always_comb begin
        sum_w  = {1'b0, cnt_i} + OFF_V;
        fold_w = (sum_w >= RES_V) ? (sum_w - RES_V) : sum_w;
        hit_w  = (SW'(fold_w) < SW'(duty_i));
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) pwm_q <= 1'b0;
        else               pwm_q <= hit_w;
    end

    assign pwm_o = pwm_q;
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm #(
    parameter int N_PHASE = 16,
    parameter int RES     = 420,
    localparam int CW     = $clog2(RES),
    localparam int DW     = $clog2(RES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DW-1:0]      duty_i,
    output logic [N_PHASE-1:0] pwm_o
);
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] duty_q;
    logic          seq_run;

    ipwm_sequencer #(.RES(RES), .CW(CW), .DW(DW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_i),
        .cnt_o  (cnt_q),
        .duty_o (duty_q),
        .run_o  (seq_run)
    );

    for (genvar k = 0; k < N_PHASE; k++) begin : g_phase
        localparam int OFF_K = (k * RES) / N_PHASE;
        ipwm_phase #(.RES(RES), .CW(CW), .DW(DW), .OFF(OFF_K)) u_ph (
            .clk    (clk),
            .rst    (rst),
            .run_i  (seq_run),
            .cnt_i  (cnt_q),
            .duty_i (duty_q),
            .pwm_o  (pwm_o[k])
        );
    end
endmodule

// File: rtl/ipwm_chk.sv
module ipwm_chk #(
    parameter int N_PHASE = 16,
    parameter int RES     = 420,
    parameter int CW      = 9,
    parameter int DW      = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic [CW-1:0]      cnt,
    input logic [DW-1:0]      duty_q,
    input logic [N_PHASE-1:0] pwm
);
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(RES));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != CW'(RES - 1)) |=> cnt == CW'($past(cnt) + 1'b1));

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != CW'(RES - 1)) |=> $stable(duty_q));

    // R4
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |=> pwm == '0);

    // R5
    duty_full_chk: assert property (@(posedge clk) disable iff (rst)
        (run && duty_q >= DW'(RES)) |=> (&pwm));

    // R7
    reset_low_chk: assert property (@(posedge clk)
        rst |=> pwm == '0);
endmodule

bind interleaved_pwm ipwm_chk #(.N_PHASE(N_PHASE), .RES(RES), .CW(CW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (seq_run),
    .cnt    (cnt_q),
    .duty_q (duty_q),
    .pwm    (pwm_o)
);

// File: tb/interleaved_pwm_test.sv
module interleaved_pwm_test;
    localparam int N   = 16;
    localparam int RES = 420;
    localparam int DW  = $clog2(RES + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] duty = '0;
    logic [N-1:0]  pwm;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R7";

    interleaved_pwm #(.N_PHASE(N), .RES(RES)) uut (
        .clk(clk), .rst(rst), .duty_i(duty), .pwm_o(pwm)
    );

    always #2.5 clk = ~clk;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, updated on every rising edge
    bit           m_run  = 0;
    int           m_cnt  = 0;
    int           m_duty = 0;
    logic [N-1:0] m_pwm  = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_cnt = 0; m_duty = 0; m_pwm = '0;
        end else begin
            for (int k = 0; k < N; k++)
                m_pwm[k] = m_run && (((m_cnt + (k * RES) / N) % RES) < m_duty);
            if (!m_run) begin
                m_run = 1; m_cnt = 0; m_duty = int'(duty);
            end else if (m_cnt == RES - 1) begin
                m_cnt = 0; m_duty = int'(duty);
            end else begin
                m_cnt++;
            end
        end
    end

    // per-cycle comparison plus rise tracking
    int cyc = 0;
    logic [N-1:0] prev_pwm = '0;
    int last_rise [N];
    int rise0_q [$];

    always @(negedge clk) begin
        cyc++;
        chk(pwm === m_pwm, cur_req, "pwm vs model", longint'(pwm), longint'(m_pwm));
        for (int k = 0; k < N; k++)
            if (pwm[k] && !prev_pwm[k]) begin
                last_rise[k] = cyc;
                if (k == 0) rise0_q.push_back(cyc);
            end
        prev_pwm = pwm;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int d, string req);
        int hi [N];
        int expv;
        expv = (d < RES) ? d : RES;
        for (int k = 0; k < N; k++) hi[k] = 0;
        repeat (RES) begin
            @(negedge clk);
            for (int k = 0; k < N; k++) hi[k] += int'(pwm[k]);
        end
        for (int k = 0; k < N; k++)
            chk(hi[k] == expv, req, $sformatf("high count phase %0d", k), hi[k], expv);
    endtask

    initial begin
        // R7: reset state
        rst = 1; duty = 100; cur_req = "R7";
        step(3);
        chk(pwm == '0, "R7", "outputs in reset", pwm, 0);

        // R8: first duty taken in the prime cycle
        rst = 0; cur_req = "R8";
        step(2);
        measure(100, "R8");

        // R3 / R9 interior duty
        duty = 105; cur_req = "R3";
        step(2 * RES);
        measure(105, "R9");

        // R1 period and R2 phase spacing
        rise0_q.delete();
        cur_req = "R1";
        step(2 * RES + 5);
        chk(rise0_q.size() >= 2, "R1", "phase 0 rises seen", rise0_q.size(), 2);
        if (rise0_q.size() >= 2)
            chk(rise0_q[$] - rise0_q[$-1] == RES, "R1", "period",
                rise0_q[$] - rise0_q[$-1], RES);
        for (int k = 1; k < N; k++) begin
            int got, want;
            got  = ((last_rise[k] - last_rise[0]) % RES + RES) % RES;
            want = (RES - (k * RES) / N) % RES;
            chk(got == want, "R2", $sformatf("rise delay phase %0d", k), got, want);
        end

        // R6: mid-period change, taken only at wrap
        step(137);
        duty = 300; cur_req = "R6";
        step(2 * RES);
        measure(300, "R6");

        // R3 boundaries of the compare
        duty = 1; cur_req = "R3";
        step(2 * RES);
        measure(1, "R3");
        duty = DW'(RES - 1);
        step(2 * RES);
        measure(RES - 1, "R3");

        // R4 duty zero
        duty = 0; cur_req = "R4";
        step(2 * RES + 2);
        chk(pwm == '0, "R4", "zero duty outputs", pwm, 0);
        measure(0, "R4");

        // R5 duty at and above range
        duty = DW'(RES); cur_req = "R5";
        step(2 * RES + 2);
        chk(&pwm, "R5", "duty RES outputs", pwm, {N{1'b1}});
        duty = '1;
        step(2 * RES + 2);
        chk(&pwm, "R5", "duty max outputs", pwm, {N{1'b1}});

        // R7 reset mid-run, then R8 new start-up duty
        step(50);
        rst = 1; duty = 200; cur_req = "R7";
        step(1);
        chk(pwm == '0, "R7", "outputs after mid-run reset", pwm, 0);
        step(2);
        rst = 0; cur_req = "R8";
        step(2);
        measure(200, "R8");
        step(RES);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule